// File: doc/BRIEF.md
# Banked Program Counter with Interrupt Vectoring

This block holds the 12-bit fetch address of a small 8-bit controller core. The address has two parts: an 11-bit offset that steps through a 2 KiB program bank, and a separate bank bit on top. Each clock the core issues at most one effective command. The commands are step, load a jump or call target, return with a popped address, or take an interrupt. A separate command writes a pending-bank flag, and that flag is consulted only when the next jump or call is loaded.

An interrupt request is turned into an injected call. The call lands at one of two fixed vectors in bank 0, chosen by the request source. The block then stays in service mode until a return that also restores status. While in service mode, every jump or call stays in bank 0 whatever the flag holds, and no further request is vectored. The return stack lives outside this block. The block takes the popped 12-bit value as an input and produces the next fetch address as a registered output.

Top module: `pc_bank_ctrl`

## Requirements
- R1: While reset is low, the fetch address is 000h. After reset the pending-bank flag is 0 and service mode is off, so a first jump to target T lands at 0T.
- R2: A step adds one to the 11-bit offset modulo 2048 and never alters bit 11. 7FFh steps to 000h and FFFh steps to 800h.
- R3: A bank-select command (value on `bank_val_i`) only writes the pending-bank flag. The fetch address is unchanged by it in that cycle, and the new flag is used from the next jump or call onward.
- R4: A jump or call outside service mode loads {pending-bank flag, 11-bit target} as the next fetch address.
- R5: A vectored interrupt loads 003h for source 0 (external) and 007h for source 1 (timer), with bit 11 at 0, whatever bank was executing. It also enters service mode.
- R6: In service mode, a jump or call loads {0, target}, ignoring the pending-bank flag.
- R7: In service mode a request is not vectored. A step issued alongside it still steps.
- R8: A return loads all 12 bits from the popped value. Service mode is left only when the return also carries the restore qualifier (`ret_restore_i` = 1). A plain return keeps it.
- R9: Per cycle priority is return, then jump or call, then interrupt, then step. A request that arrives together with a jump does not touch that jump's bank bit. It is vectored in the next free cycle if still asserted.
- R10: With no command, the fetch address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step_i | input | 1 | Advance the offset by one |
| jump_i | input | 1 | Load a jump or call target |
| target_i | input | 11 | Offset part of the jump or call target |
| bank_sel_i | input | 1 | Write the pending-bank flag |
| bank_val_i | input | 1 | Value written into the pending-bank flag |
| irq_i | input | 1 | Interrupt request, level |
| irq_src_i | input | 1 | Request source: 0 external, 1 timer |
| ret_i | input | 1 | Load the popped return address |
| ret_restore_i | input | 1 | Return also leaves service mode |
| ret_pc_i | input | 12 | Popped 12-bit return address |
| pc_o | output | 12 | Fetch address |

## Verification
Some rules are checked on every cycle by properties on the registered address. A step keeps bit 11 and adds one to the offset. A vectored cycle lands on one of the two bank-0 vectors. A jump in service mode stays in bank 0. A return copies the popped value. An idle cycle holds the address. Other behaviour needs directed sequences whose effect shows up only several cycles later. These are the delayed effect of the bank flag, the difference between the two return kinds, the blocking of nested requests, and a request deferred behind a simultaneous jump.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_STEP = 3'd1,
    OP_VEC  = 3'd2,
    OP_JMP  = 3'd3,
    OP_RET  = 3'd4
  } pc_op_e;
endpackage

// File: rtl/pcb_arbiter.sv
module pcb_arbiter
  import pcb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step_i,
  input  logic   jump_i,
  input  logic   irq_i,
  input  logic   ret_i,
  input  logic   in_service_i,
  output pc_op_e op_o
);
  always_comb begin
    if (ret_i)                          op_o = OP_RET;
    else if (jump_i)                    op_o = OP_JMP;
    else if (irq_i && !in_service_i)    op_o = OP_VEC;
    else if (step_i)                    op_o = OP_STEP;
    else                                op_o = OP_HOLD;
  end

  // R7
  no_nested_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_service_i |-> (op_o != OP_VEC));

  // R9
  jump_over_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_i && !ret_i) |-> (op_o == OP_JMP));
endmodule

// File: rtl/pcb_mode_regs.sv
module pcb_mode_regs
  import pcb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  pc_op_e op_i,
  input  logic   bank_sel_i,
  input  logic   bank_val_i,
  input  logic   ret_restore_i,
  output logic   bank_flag_o,
  output logic   in_service_o
);
  logic bank_q, bank_d;
  logic svc_q, svc_d;
  logic bank_en, svc_en;

  always_comb begin
    bank_en = bank_sel_i;
    bank_d  = bank_val_i;
    svc_en  = 1'b0;
    svc_d   = svc_q;
    if (op_i == OP_VEC) begin
      svc_en = 1'b1;
      svc_d  = 1'b1;
    end else if (op_i == OP_RET && ret_restore_i) begin
      svc_en = 1'b1;
      svc_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      if (bank_en) bank_q <= bank_d;
      if (svc_en)  svc_q  <= svc_d;
    end
  end

  assign bank_flag_o  = bank_q;
  assign in_service_o = svc_q;

  // R8
  plain_ret_keeps_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RET && !ret_restore_i) |=> (svc_q == $past(svc_q)));
endmodule

// File: rtl/pcb_addr_path.sv
module pcb_addr_path
  import pcb_pkg::*;
#(
  parameter int unsigned OFS_W   = 11,
  parameter int unsigned EXT_VEC = 3,
  parameter int unsigned TMR_VEC = 7,
  localparam int unsigned PC_W   = OFS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pc_op_e           op_i,
  input  logic [OFS_W-1:0] target_i,
  input  logic [PC_W-1:0]  ret_pc_i,
  input  logic             bank_flag_i,
  input  logic             in_service_i,
  input  logic             irq_src_i,
  output logic [PC_W-1:0]  pc_o
);
  localparam logic [OFS_W-1:0] VEC_EXT = OFS_W'(EXT_VEC);
  localparam logic [OFS_W-1:0] VEC_TMR = OFS_W'(TMR_VEC);

  logic             bank_q, bank_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic             pc_en;

  always_comb begin
    pc_en  = 1'b1;
    bank_d = bank_q;
    ofs_d  = ofs_q;
    unique case (op_i)
      OP_RET: begin
        bank_d = ret_pc_i[PC_W-1];
        ofs_d  = ret_pc_i[OFS_W-1:0];
      end
      OP_JMP: begin
        bank_d = bank_flag_i & ~in_service_i;
        ofs_d  = target_i;
      end
      OP_VEC: begin
        bank_d = 1'b0;
        ofs_d  = irq_src_i ? VEC_TMR : VEC_EXT;
      end
      OP_STEP: ofs_d = ofs_q + 1'b1;
      default: pc_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      ofs_q  <= '0;
    end else if (pc_en) begin
      bank_q <= bank_d;
      ofs_q  <= ofs_d;
    end
  end

  assign pc_o = {bank_q, ofs_q};

  // R2
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_STEP) |=> (bank_q == $past(bank_q)) &&
                          (ofs_q == OFS_W'($past(ofs_q) + 1'b1)));

  // R5
  vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_VEC) |=> !bank_q && (ofs_q == VEC_EXT || ofs_q == VEC_TMR));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_HOLD) |=> $stable(pc_o));
endmodule

// File: rtl/pc_bank_ctrl.sv
module pc_bank_ctrl
  import pcb_pkg::*;
#(
  parameter int unsigned OFS_W   = 11,
  parameter int unsigned EXT_VEC = 3,
  parameter int unsigned TMR_VEC = 7,
  localparam int unsigned PC_W   = OFS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             jump_i,
  input  logic [OFS_W-1:0] target_i,
  input  logic             bank_sel_i,
  input  logic             bank_val_i,
  input  logic             irq_i,
  input  logic             irq_src_i,
  input  logic             ret_i,
  input  logic             ret_restore_i,
  input  logic [PC_W-1:0]  ret_pc_i,
  output logic [PC_W-1:0]  pc_o
);
  pc_op_e op;
  logic   bank_flag;
  logic   in_service;

  pcb_arbiter i_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_i       (step_i),
    .jump_i       (jump_i),
    .irq_i        (irq_i),
    .ret_i        (ret_i),
    .in_service_i (in_service),
    .op_o         (op)
  );

  pcb_mode_regs i_mode (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_i          (op),
    .bank_sel_i    (bank_sel_i),
    .bank_val_i    (bank_val_i),
    .ret_restore_i (ret_restore_i),
    .bank_flag_o   (bank_flag),
    .in_service_o  (in_service)
  );

  pcb_addr_path #(
    .OFS_W   (OFS_W),
    .EXT_VEC (EXT_VEC),
    .TMR_VEC (TMR_VEC)
  ) i_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op),
    .target_i     (target_i),
    .ret_pc_i     (ret_pc_i),
    .bank_flag_i  (bank_flag),
    .in_service_i (in_service),
    .irq_src_i    (irq_src_i),
    .pc_o         (pc_o)
  );

  // R6
  svc_jump_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service && jump_i && !ret_i) |=> !pc_o[PC_W-1]);

  // R8
  ret_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |=> (pc_o == $past(ret_pc_i)));

  // R3
  bank_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel_i && !jump_i && !ret_i && !irq_i && !step_i) |=> $stable(pc_o));
endmodule

// File: tb/test_pc_bank_ctrl.sv
module test_pc_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i, jump_i, bank_sel_i, bank_val_i;
  logic        irq_i, irq_src_i, ret_i, ret_restore_i;
  logic [10:0] target_i;
  logic [11:0] ret_pc_i;
  logic [11:0] pc_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pc_bank_ctrl i_pc_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .jump_i(jump_i),
    .target_i(target_i), .bank_sel_i(bank_sel_i), .bank_val_i(bank_val_i),
    .irq_i(irq_i), .irq_src_i(irq_src_i), .ret_i(ret_i),
    .ret_restore_i(ret_restore_i), .ret_pc_i(ret_pc_i), .pc_o(pc_o)
  );

  task automatic chk(input string tag, input logic [11:0] exp);
    checks++;
    if (pc_o !== exp) begin
      errors++;
      $display("FAIL %s: pc_o actual %03h expected %03h", tag, pc_o, exp);
    end
  endtask

  task automatic idle_inputs();
    step_i = 0; jump_i = 0; target_i = '0; bank_sel_i = 0; bank_val_i = 0;
    irq_i = 0; irq_src_i = 0; ret_i = 0; ret_restore_i = 0; ret_pc_i = '0;
  endtask

  // inputs are set just after a falling edge; one rising edge later the result is sampled
  task automatic tick();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_step();                 step_i = 1; tick(); endtask
  task automatic do_jump(input logic [10:0] t); jump_i = 1; target_i = t; tick(); endtask
  task automatic do_bank(input logic v);    bank_sel_i = 1; bank_val_i = v; tick(); endtask
  task automatic do_irq(input logic s);     irq_i = 1; irq_src_i = s; tick(); endtask
  task automatic do_ret(input logic [11:0] p, input logic rs);
    ret_i = 1; ret_pc_i = p; ret_restore_i = rs; tick();
  endtask

  task automatic t_reset();
    rst_n = 0; idle_inputs();
    repeat (3) @(negedge clk);
    chk("R1 reset address", 12'h000);
    rst_n = 1;
    @(negedge clk);
    do_jump(11'h155); chk("R1 flag clear after reset", 12'h155);
  endtask

  task automatic t_step();
    do_jump(11'h7FE); chk("R4 jump bank 0", 12'h7FE);
    do_step();        chk("R2 step", 12'h7FF);
    do_step();        chk("R2 wrap bank 0", 12'h000);
    do_bank(1'b1);    chk("R3 bank select no immediate effect", 12'h000);
    do_step();        chk("R3 step after select stays bank 0", 12'h001);
    do_jump(11'h7FE); chk("R4 jump uses flag", 12'hFFE);
    do_step();        chk("R2 step bank 1", 12'hFFF);
    do_step();        chk("R2 wrap bank 1", 12'h800);
    tick(); tick();   chk("R10 hold", 12'h800);
  endtask

  task automatic t_service();
    do_irq(1'b0);     chk("R5 external vector from bank 1", 12'h003);
    step_i = 1; irq_i = 1; tick(); chk("R7 no nested vector", 12'h004);
    do_jump(11'h200); chk("R6 jump in service bank 0", 12'h200);
    do_ret(12'h801, 1'b1); chk("R8 restore return", 12'h801);
    do_jump(11'h010); chk("R8 service left, flag applies", 12'h810);
    do_irq(1'b1);     chk("R5 timer vector", 12'h007);
    do_ret(12'hABC, 1'b0); chk("R8 plain return loads 12 bits", 12'hABC);
    do_jump(11'h011); chk("R8 plain return keeps service", 12'h011);
    do_ret(12'h900, 1'b1); chk("R8 restore return bank 1", 12'h900);
  endtask

  task automatic t_priority();
    jump_i = 1; target_i = 11'h345; irq_i = 1; irq_src_i = 0; tick();
    chk("R9 jump keeps bank bit under irq", 12'hB45);
    do_irq(1'b0);     chk("R9 deferred vector", 12'h003);
    ret_i = 1; ret_pc_i = 12'h456; ret_restore_i = 1; jump_i = 1; target_i = 11'h111; tick();
    chk("R9 return over jump", 12'h456);
    jump_i = 1; target_i = 11'h020; step_i = 1; tick();
    chk("R9 jump over step", 12'h820);
    do_bank(1'b0); do_jump(11'h030); chk("R3 flag cleared", 12'h030);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_step();
    t_service();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule